// File: doc/BRIEF.md
# Laser Drive Safety Controller

This block decides, cycle by cycle, whether the laser drive current source may run. It also controls an active-high output that opens an external supply switch. A mode bit picks one of two drive modes. In continuous mode the drive runs whenever the device is not powered down. In shutter mode the drive runs only while the imaging sequencer's illumination window is open. A power-down input forces the drive off and opens the supply switch.

Comparator outputs watch two pins for a short to ground: the bias pin and the laser output pin. Either indication passes through a two-flop synchronizer and then sets a sticky fault. The fault keeps the drive off and the supply switch open until reset.

Each write strobe to the power-setting register starts a four-phase self-test of the laser output pin. Each phase lasts `STEP_CYCLES` clocks, and the drive is held off for the whole test. The phases run in this order:
- a check for a short to ground;
- a check for a short to the laser supply;
- an injection phase that asks the analog detector to report a fault and expects it to do so;
- a recovery phase that lets the injected indication drain through the synchronizer.

A failing phase ends the test early, records which phase failed, and sets the sticky fault.

Top module: `laser_safety_ctrl`

## Requirements
- R1: After reset the following hold: `drive_en`=0, `supply_off`=0, `test_inject`=0 and `status`=0. The mode register resets to shutter mode (1).
- R2: In shutter mode, with no fault, no test running and no power-down, `drive_en` follows `illum_win` one clock later.
- R3: Writing the mode register with 0 (via `mode_wr` with value `mode_shutter_in`) selects continuous mode. In that mode `drive_en` is 1 one clock later, whatever `illum_win` is, provided there is no fault, no test running and no power-down.
- R4: While `pwrdn`=1, `drive_en` is 0 and `supply_off` is 1 from the next clock, in either mode.
- R5: A bias-pin short indication (`flt_bias_gnd`=1) sets the fault. While the fault is set, `status[0]`=1, `drive_en`=0 and `supply_off`=1, and all three stay so after the indication goes away.
- R6: An output-pin ground short indication (`flt_out_gnd`=1) outside the injection and recovery phases sets the same sticky fault.
- R7: Power-down does not clear a set fault; only `rst` does.
- R8: A `pwr_cfg_wr` pulse starts the self-test. While the test runs, `status[1]`=1 and `drive_en`=0. `test_inject`=1 only during the third phase, which spans clocks 2*STEP_CYCLES to 3*STEP_CYCLES-1 after the strobe.
- R9: A passing self-test ends 4*STEP_CYCLES clocks after the strobe. It leaves `status`=0, and the injected ground indication does not set the fault.
- R10: A supply-short indication (`flt_out_sup`) has no effect outside a self-test. During the test's second phase it sets `status[3]` and the fault.
- R11: If the output-pin ground indication is still absent at the end of the injection phase, the test sets `status[4]` and the fault.
- R12: A ground short present during the test's first phase sets `status[2]` and the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_shutter_in | input | 1 | Mode value to write: 1 = shutter, 0 = continuous |
| pwr_cfg_wr | input | 1 | Write strobe of the power-setting register; starts the self-test |
| pwrdn | input | 1 | Power-down request, active high |
| illum_win | input | 1 | Illumination window from the imaging sequencer |
| flt_bias_gnd | input | 1 | Comparator: bias pin shorted to ground |
| flt_out_gnd | input | 1 | Comparator: laser output pin shorted to ground |
| flt_out_sup | input | 1 | Comparator: laser output pin shorted to the laser supply |
| drive_en | output | 1 | Enable for the laser drive current source |
| supply_off | output | 1 | Opens the external supply switch, active high |
| test_inject | output | 1 | Asks the analog detector to report a fault (injection phase) |
| status | output | 5 | Bit 0 fault, bit 1 test busy, bit 2 ground-phase fail, bit 3 supply-phase fail, bit 4 injection-phase fail |

## Verification
The enable path is driven in both modes with the window open and closed, and with power-down. This separates the mode selection from the power-down override.

Shorts on each pin are applied and then removed. This shows whether the fault is sticky, and that power-down leaves it set while reset clears it. The supply-short input is raised both with no test running and inside a test, which confirms it counts only in its own phase.

Self-tests are run in four cases: fault-free, with a supply short, with a ground short, and with a detector that never answers the injection. Each case must set its own phase bit. The fault-free run also shows where the injection output sits in time and that the injected indication does not latch a fault.

// File: rtl/laser_safety_pkg.sv
package laser_safety_pkg;
  localparam int STAT_W     = 5;
  localparam int STAT_FAULT = 0;
  localparam int STAT_BUSY  = 1;
  localparam int STAT_FGND  = 2;
  localparam int STAT_FSUP  = 3;
  localparam int STAT_FINJ  = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_GND,
    PH_SUP,
    PH_INJ,
    PH_RCV
  } st_phase_e;
endpackage

// File: rtl/laser_sync.sv
module laser_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/laser_selftest.sv
module laser_selftest
  import laser_safety_pkg::*;
#(
  parameter int STEP_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       gnd_s,
  input  logic       sup_s,
  output logic       busy,
  output logic       inject,
  output logic       mask,
  output logic       fail_evt,
  output logic [2:0] step_fail
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  st_phase_e     phase;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      step_fail <= '0;
      fail_evt  <= 1'b0;
    end else begin
      fail_evt <= 1'b0;
      if (start) begin
        phase     <= PH_GND;
        cnt       <= '0;
        step_fail <= '0;
      end else if (phase != PH_IDLE) begin
        if (cnt != LAST) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          case (phase)
            PH_GND: if (gnd_s) begin
                      step_fail[0] <= 1'b1;
                      fail_evt     <= 1'b1;
                      phase        <= PH_IDLE;
                    end else phase <= PH_SUP;
            PH_SUP: if (sup_s) begin
                      step_fail[1] <= 1'b1;
                      fail_evt     <= 1'b1;
                      phase        <= PH_IDLE;
                    end else phase <= PH_INJ;
            PH_INJ: if (!gnd_s) begin
                      step_fail[2] <= 1'b1;
                      fail_evt     <= 1'b1;
                      phase        <= PH_IDLE;
                    end else phase <= PH_RCV;
            default: phase <= PH_IDLE;
          endcase
        end
      end
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign inject = (phase == PH_INJ);
  assign mask   = (phase == PH_INJ) || (phase == PH_RCV);
endmodule

// File: rtl/laser_fault_latch.sv
module laser_fault_latch (
  input  logic clk,
  input  logic rst,
  input  logic bias_s,
  input  logic gnd_s,
  input  logic mask,
  input  logic fail_evt,
  output logic fault
);
  always_ff @(posedge clk) begin
    if (rst) fault <= 1'b0;
    else     fault <= fault | bias_s | (gnd_s & ~mask) | fail_evt;
  end
endmodule

// File: rtl/laser_drive_out.sv
module laser_drive_out (
  input  logic clk,
  input  logic rst,
  input  logic shutter,
  input  logic illum_win,
  input  logic pwrdn,
  input  logic fault,
  input  logic busy,
  output logic drive_en,
  output logic supply_off
);
  logic want;
  assign want = shutter ? illum_win : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en   <= 1'b0;
      supply_off <= 1'b0;
    end else begin
      drive_en   <= want & ~fault & ~busy & ~pwrdn;
      supply_off <= fault | pwrdn;
    end
  end
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl
  import laser_safety_pkg::*;
#(
  parameter int STEP_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic              mode_shutter_in,
  input  logic              pwr_cfg_wr,
  input  logic              pwrdn,
  input  logic              illum_win,
  input  logic              flt_bias_gnd,
  input  logic              flt_out_gnd,
  input  logic              flt_out_sup,
  output logic              drive_en,
  output logic              supply_off,
  output logic              test_inject,
  output logic [STAT_W-1:0] status
);
  logic       mode_q;
  logic [2:0] flt_s;
  logic       busy, mask, fail_evt, fault;
  logic [2:0] step_fail;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 1'b1;
    else if (mode_wr) mode_q <= mode_shutter_in;
  end

  laser_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({flt_out_sup, flt_out_gnd, flt_bias_gnd}),
    .q   (flt_s)
  );

  laser_selftest #(.STEP_CYCLES(STEP_CYCLES)) i_test (
    .clk       (clk),
    .rst       (rst),
    .start     (pwr_cfg_wr),
    .gnd_s     (flt_s[1]),
    .sup_s     (flt_s[2]),
    .busy      (busy),
    .inject    (test_inject),
    .mask      (mask),
    .fail_evt  (fail_evt),
    .step_fail (step_fail)
  );

  laser_fault_latch i_latch (
    .clk      (clk),
    .rst      (rst),
    .bias_s   (flt_s[0]),
    .gnd_s    (flt_s[1]),
    .mask     (mask),
    .fail_evt (fail_evt),
    .fault    (fault)
  );

  laser_drive_out i_out (
    .clk        (clk),
    .rst        (rst),
    .shutter    (mode_q),
    .illum_win  (illum_win),
    .pwrdn      (pwrdn),
    .fault      (fault),
    .busy       (busy),
    .drive_en   (drive_en),
    .supply_off (supply_off)
  );

  always_comb begin
    status             = '0;
    status[STAT_FAULT] = fault;
    status[STAT_BUSY]  = busy;
    status[STAT_FGND]  = step_fail[0];
    status[STAT_FSUP]  = step_fail[1];
    status[STAT_FINJ]  = step_fail[2];
  end
endmodule

// File: rtl/laser_safety_chk.sv
module laser_safety_chk (
  input logic clk,
  input logic rst,
  input logic pwrdn,
  input logic shutter,
  input logic illum_win,
  input logic drive_en,
  input logic supply_off,
  input logic test_inject,
  input logic busy,
  input logic fault
);
  AST_SHUTTER_DARK: assert property (@(posedge clk) disable iff (rst)
    (shutter && !illum_win) |=> !drive_en); // R2
  AST_CONT_ON: assert property (@(posedge clk) disable iff (rst)
    (!shutter && !fault && !busy && !pwrdn) |=> drive_en); // R3
  AST_PWRDN_OFF: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> (supply_off && !drive_en)); // R4
  AST_SWITCH_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (!fault && !pwrdn) |=> !supply_off); // R4
  AST_FAULT_KILL: assert property (@(posedge clk) disable iff (rst)
    fault |=> (!drive_en && supply_off)); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault); // R7
  AST_BUSY_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !drive_en); // R8
  AST_INJECT_IN_TEST: assert property (@(posedge clk) disable iff (rst)
    test_inject |-> busy); // R8
endmodule

bind laser_safety_ctrl laser_safety_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .pwrdn       (pwrdn),
  .shutter     (mode_q),
  .illum_win   (illum_win),
  .drive_en    (drive_en),
  .supply_off  (supply_off),
  .test_inject (test_inject),
  .busy        (status[1]),
  .fault       (status[0])
);

// File: tb/test_laser_safety_ctrl.sv
module test_laser_safety_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  typedef struct {
    string      tag;
    logic       drv;
    logic       off;
    logic       inj;
    logic [4:0] st;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 0, mode_shutter_in = 0, pwr_cfg_wr = 0, pwrdn = 0, illum_win = 0;
  logic sh_bias = 0, sh_gnd = 0, sh_sup = 0, det_ok = 1;
  logic flt_bias_gnd, flt_out_gnd, flt_out_sup;
  logic drive_en, supply_off, test_inject;
  logic [4:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign flt_bias_gnd = sh_bias;
  assign flt_out_gnd  = sh_gnd | (test_inject & det_ok);
  assign flt_out_sup  = sh_sup;

  laser_safety_ctrl #(.STEP_CYCLES(STEP)) i_laser_safety_ctrl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_shutter_in(mode_shutter_in),
    .pwr_cfg_wr(pwr_cfg_wr), .pwrdn(pwrdn), .illum_win(illum_win),
    .flt_bias_gnd(flt_bias_gnd), .flt_out_gnd(flt_out_gnd), .flt_out_sup(flt_out_sup),
    .drive_en(drive_en), .supply_off(supply_off), .test_inject(test_inject),
    .status(status)
  );

  // monitor: compares the oldest expected item at each falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (drive_en !== e.drv || supply_off !== e.off || test_inject !== e.inj || status !== e.st) begin
        n_fail++;
        $display("FAIL %s: got drv=%b off=%b inj=%b st=%b, exp drv=%b off=%b inj=%b st=%b",
                 e.tag, drive_en, supply_off, test_inject, status, e.drv, e.off, e.inj, e.st);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // driver side: queue an expectation, sampled at the next falling edge
  task automatic expect_out(input string tag, input logic drv, input logic off,
                            input logic inj, input logic [4:0] st);
    exp_t e;
    e.tag = tag; e.drv = drv; e.off = off; e.inj = inj; e.st = st;
    q.push_back(e);
    cyc(1);
  endtask

  task automatic do_reset();
    rst = 1; cyc(3); rst = 0; cyc(1);
  endtask

  task automatic start_test();
    pwr_cfg_wr = 1; cyc(1); pwr_cfg_wr = 0;
  endtask

  task automatic set_mode(input logic sh);
    mode_shutter_in = sh; mode_wr = 1; cyc(1); mode_wr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got running exp finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    expect_out("R1 reset state", 0, 0, 0, 5'b00000);
    illum_win = 1; cyc(1);
    expect_out("R1 shutter default / R2 window open", 1, 0, 0, 5'b00000);
    illum_win = 0; cyc(1);
    expect_out("R2 window closed", 0, 0, 0, 5'b00000);

    set_mode(0); cyc(1);
    expect_out("R3 continuous with window closed", 1, 0, 0, 5'b00000);
    pwrdn = 1;
    expect_out("R4 power-down next clock", 0, 1, 0, 5'b00000);
    pwrdn = 0; cyc(1);
    expect_out("R4 power-down released", 1, 0, 0, 5'b00000);

    sh_sup = 1; cyc(5);
    expect_out("R10 supply short ignored outside test", 1, 0, 0, 5'b00000);
    sh_sup = 0; cyc(3);

    // fault-free self-test; strobe seen at edge e0
    start_test();
    expect_out("R8 busy in first phase", 0, 0, 0, 5'b00010);
    cyc(7);
    expect_out("R8 inject in third phase", 0, 0, 1, 5'b00010);
    cyc(2);
    expect_out("R8 inject ends with third phase", 0, 0, 0, 5'b00010);
    cyc(8);
    expect_out("R9 passing test leaves clean status", 1, 0, 0, 5'b00000);

    sh_sup = 1; start_test(); cyc(25); sh_sup = 0;
    expect_out("R10 supply short in test", 0, 1, 0, 5'b01001);
    pwrdn = 1; cyc(3); pwrdn = 0; cyc(3);
    expect_out("R7 power-down keeps fault", 0, 1, 0, 5'b01001);
    do_reset();
    expect_out("R7 reset clears fault", 0, 0, 0, 5'b00000);

    det_ok = 0; start_test(); cyc(25);
    expect_out("R11 detector silent", 0, 1, 0, 5'b10001);
    det_ok = 1; do_reset();

    illum_win = 1; sh_bias = 1; cyc(6);
    expect_out("R5 bias short", 0, 1, 0, 5'b00001);
    sh_bias = 0; cyc(5);
    expect_out("R5 bias fault sticky", 0, 1, 0, 5'b00001);
    do_reset();
    expect_out("R5 cleared by reset", 1, 0, 0, 5'b00000);

    sh_gnd = 1; cyc(6);
    expect_out("R6 output ground short", 0, 1, 0, 5'b00001);
    sh_gnd = 0; cyc(5);
    expect_out("R6 ground fault sticky", 0, 1, 0, 5'b00001);
    do_reset();

    sh_gnd = 1; start_test(); cyc(25); sh_gnd = 0;
    expect_out("R12 ground phase fails", 0, 1, 0, 5'b00101);

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule